// File: doc/BRIEF.md
# Staggered Analog Switch Turn-On Sequencer

This block decides when each of five analog switches of a headset path turns on: left audio, right audio, microphone, ground sense and audio ground. It outputs only digital controls. For each switch it gives an enable, a ramp-phase flag and a fully-on flag. The gate-drive ramp itself lives in analog circuitry that these flags steer. A single-cycle `tick` input gives the time base, with one tick every 50 ms. Every delay and ramp time is a whole number of ticks.

In staggered mode the left channel is the timing reference. It turns on at the first tick after it is requested. Each other switch waits a programmed delay, counted from the tick on which the left channel turned on. Each switch then spends a programmed ramp time in its ramp phase before it reports fully on. The ramp code maps to time differently for each switch type. In direct mode, every requested switch goes straight to fully on at the next tick. Dropping a request turns that switch off at once. A one-cycle completion pulse marks the moment every requested switch is fully on.

Top module: `slow_on_seq`

## Requirements
- R1: While reset is held and right after it, `sw_en`, `sw_ramping`, `sw_full` and `seq_done` are all 0. Channel bit order in every vector is: bit 0 left, bit 1 right, bit 2 microphone, bit 3 sense, bit 4 audio ground.
- R2: With `slow_en`=1, the left switch turns on (enable and ramp flag rise) on the first `tick` at which `sw_req[0]` is 1.
- R3: With `slow_en`=1, a non-left switch i turns on at the first tick at which at least 2·`delay_code[i-1]` ticks have passed since the left switch's turn-on tick (code × 100 ms). It never turns on while `sw_req[0]` is 0.
- R4: The left, right and sense switches ramp for 2·(code+1) ticks, which is (code+1) × 100 ms. They then show `sw_full`=1 and `sw_ramping`=0.
- R5: The microphone switch ramps for 2·code+3 ticks (100·code+150 ms), so code 1 gives 250 ms. Code 0 behaves as code 1.
- R6: The audio-ground switch ramps for 14·(code+1) ticks, which is (code+1) × 700 ms.
- R7: With `slow_en`=0, every requested switch goes from off straight to `sw_full`=1 on the next tick, with no ramp phase and no delay.
- R8: When `sw_req[i]` is 0, switch i shows all flags 0 after the next clock edge, whatever its phase and whether or not a tick occurs. A later request starts it again from off.
- R9: `seq_done` is a single-cycle pulse, raised in the cycle after the edge where all requested switches (at least one) are first fully on.
- R10: `sw_en[i]` equals `sw_ramping[i]` OR `sw_full[i]`, and `sw_ramping[i]` and `sw_full[i]` are never both 1.
- R11: A switch leaves the off state only on a clock edge where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 50 ms |
| slow_en | input | 1 | 1: staggered turn-on with ramps; 0: direct turn-on |
| sw_req | input | 5 | Per-switch turn-on request |
| ramp_code | input | 5×8 | Per-switch ramp time code, indexed like `sw_req` |
| delay_code | input | 4×8 | Delay code of switch j+1 relative to left, entry j |
| sw_en | output | 5 | Switch enabled (ramping or fully on) |
| sw_ramping | output | 5 | Switch in ramp phase |
| sw_full | output | 5 | Switch fully on |
| seq_done | output | 1 | Pulse: all requested switches fully on |

## Verification
The bench compares every tick against turn-on and fully-on tick numbers that it works out from the millisecond formulas. An off-by-one in any tick mapping would move the ramp end by a tick and show up at once. It targets the microphone code 0 and the odd 150 ms offset, which a design reusing the audio mapping would get wrong. It also runs the largest audio-ground and delay codes, where too narrow a counter would wrap and end early. It checks that switches wait while the left request is missing, which a design ignoring the reference would turn on. It drops a request in mid-ramp and then re-requests it, so a design that kept a stale count or a stale delay reference would show a wrong ramp length.

// File: rtl/slow_on_pkg.sv
package slow_on_pkg;
  localparam int NCH     = 5;
  localparam int CODE_W  = 8;
  localparam int CNT_W   = 12;
  localparam int AGE_W   = CODE_W + 1;

  localparam int CH_LEFT = 0;
  localparam int CH_MIC  = 2;
  localparam int CH_AGND = 4;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RAMP = 2'd1,
    ST_FULL = 2'd2
  } sw_state_e;

  // Ramp duration in 50 ms ticks for a channel and its code.
  function automatic logic [CNT_W-1:0] ramp_ticks(input int ch, input logic [CODE_W-1:0] code);
    int c;
    int t;
    c = int'(code);
    if (ch == CH_MIC) begin
      if (c == 0) c = 1;
      t = 3 + 2 * c;
    end else if (ch == CH_AGND) begin
      t = 14 * (c + 1);
    end else begin
      t = 2 * (c + 1);
    end
    return CNT_W'(t);
  endfunction

  // Delay in ticks: two ticks per code step.
  function automatic logic [AGE_W-1:0] delay_ticks(input logic [CODE_W-1:0] code);
    return {code, 1'b0};
  endfunction
endpackage

// File: rtl/slow_on_ref_timer.sv
module slow_on_ref_timer
  import slow_on_pkg::*;
#(
  parameter int W = AGE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ref_req,
  input  logic         ref_active,
  output logic [W-1:0] age_now
);
  localparam logic [W-1:0] AGE_MAX = {W{1'b1}};

  logic [W-1:0] age_q;
  logic [W-1:0] age_d;

  always_comb begin
    age_now = ref_active ? age_q : '0;
  end

  always_comb begin
    age_d = age_q;
    if (!ref_req) begin
      age_d = '0;
    end else if (tick) begin
      age_d = (age_now == AGE_MAX) ? AGE_MAX : age_now + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  AST_AGE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_active && $past(ref_active) && $past(ref_req)) |-> (age_q >= $past(age_q))); // R3
endmodule

// File: rtl/slow_on_chan.sv
module slow_on_chan
  import slow_on_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         req,
  input  logic         slow_en,
  input  logic         go,
  input  logic [W-1:0] ramp_len,
  output logic         en,
  output logic         ramping,
  output logic         full
);
  sw_state_e    state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!req) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        ST_OFF: begin
          if (!slow_en) begin
            state_d = ST_FULL;
          end else if (go) begin
            state_d = ST_RAMP;
            cnt_d   = ramp_len - 1'b1;
          end
        end
        ST_RAMP: begin
          if (cnt_q == '0) state_d = ST_FULL;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ramping = (state_q == ST_RAMP);
  assign full    = (state_q == ST_FULL);
  assign en      = (state_q != ST_OFF);

  AST_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !en); // R8
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(tick)); // R11
  AST_FAST_NO_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramping) |-> $past(slow_en)); // R7
  AST_FULL_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full) && $past(slow_en)) |-> $past(ramping)); // R4
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramping, full})); // R10
endmodule

// File: rtl/slow_on_done.sv
module slow_on_done
  import slow_on_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] full,
  output logic         done
);
  logic all_done;
  logic all_done_q;

  assign all_done = (|req) && (&(~req | full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_done_q <= 1'b0;
    else        all_done_q <= all_done;
  end

  assign done = all_done && !all_done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/slow_on_seq.sv
module slow_on_seq
  import slow_on_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         slow_en,
  input  logic [NCH-1:0]               sw_req,
  input  logic [NCH-1:0][CODE_W-1:0]   ramp_code,
  input  logic [NCH-2:0][CODE_W-1:0]   delay_code,
  output logic [NCH-1:0]               sw_en,
  output logic [NCH-1:0]               sw_ramping,
  output logic [NCH-1:0]               sw_full,
  output logic                         seq_done
);
  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic [AGE_W-1:0] age_now;
  logic [NCH-1:0]   go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  slow_on_ref_timer #(.W(AGE_W)) u_ref (
    .clk        (clk),
    .rst_n      (rst_s),
    .tick       (tick),
    .ref_req    (sw_req[CH_LEFT]),
    .ref_active (sw_en[CH_LEFT]),
    .age_now    (age_now)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    if (ch == CH_LEFT) begin : g_ref
      assign go[ch] = 1'b1;
    end else begin : g_follow
      assign go[ch] = sw_req[CH_LEFT] && (age_now >= delay_ticks(delay_code[ch-1]));

      AST_WAIT_LEFT: assert property (@(posedge clk) disable iff (!rst_s)
        ($rose(sw_en[ch]) && $past(slow_en)) |-> $past(sw_req[CH_LEFT])); // R3
    end

    slow_on_chan #(.W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s),
      .tick     (tick),
      .req      (sw_req[ch]),
      .slow_en  (slow_en),
      .go       (go[ch]),
      .ramp_len (ramp_ticks(ch, ramp_code[ch])),
      .en       (sw_en[ch]),
      .ramping  (sw_ramping[ch]),
      .full     (sw_full[ch])
    );
  end

  slow_on_done #(.N(NCH)) u_done (
    .clk   (clk),
    .rst_n (rst_s),
    .req   (sw_req),
    .full  (sw_full),
    .done  (seq_done)
  );
endmodule

// File: tb/tb_slow_on_seq.sv
module tb_slow_on_seq;
  localparam int NC = 5;
  localparam int INF = 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic slow_en = 1'b1;
  logic [NC-1:0] sw_req = '0;
  logic [NC-1:0][7:0] ramp_code;
  logic [NC-2:0][7:0] delay_code;
  logic [NC-1:0] sw_en, sw_ramping, sw_full;
  logic seq_done;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;

  always #4 clk = ~clk;

  slow_on_seq dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slow_en(slow_en), .sw_req(sw_req),
    .ramp_code(ramp_code), .delay_code(delay_code),
    .sw_en(sw_en), .sw_ramping(sw_ramping), .sw_full(sw_full), .seq_done(seq_done)
  );

  always @(negedge clk) if (seq_done) done_seen++;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_ramp(input int ch, input int code);
    int c;
    c = code;
    if (ch == 2) begin
      if (c == 0) c = 1;
      return (150 + 100 * c) / 50;
    end
    if (ch == 4) return (700 * (c + 1)) / 50;
    return (100 * (c + 1)) / 50;
  endfunction

  function automatic string ramp_tag(input int ch);
    if (ch == 2) return "R5";
    if (ch == 4) return "R6";
    return "R4";
  endfunction

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input logic slow, input logic [NC-1:0] rq,
                          input int rc[NC], input int dc[NC-1]);
    int e[NC];
    int f[NC];
    int fmax;
    int nt;
    int d0;
    bit fin;
    for (int ch = 0; ch < NC; ch++) begin
      ramp_code[ch] = 8'(rc[ch]);
      if (ch > 0) delay_code[ch-1] = 8'(dc[ch-1]);
      if (!rq[ch]) begin e[ch] = INF; f[ch] = INF; end
      else if (!slow) begin e[ch] = 0; f[ch] = 0; end
      else if (ch == 0) begin e[ch] = 0; f[ch] = exp_ramp(0, rc[0]); end
      else if (!rq[0]) begin e[ch] = INF; f[ch] = INF; end
      else begin e[ch] = 2 * dc[ch-1]; f[ch] = e[ch] + exp_ramp(ch, rc[ch]); end
    end
    fmax = -1; fin = 1;
    for (int ch = 0; ch < NC; ch++) if (rq[ch]) begin
      if (f[ch] == INF) fin = 0;
      else if (f[ch] > fmax) fmax = f[ch];
    end
    if (rq == '0) fin = 0;
    nt = fin ? fmax + 2 : 12;
    slow_en = slow;
    sw_req = rq;
    d0 = done_seen;
    repeat (3) @(negedge clk);
    chk("R11", "en before any tick", int'(sw_en), 0);
    for (int k = 0; k <= nt; k++) begin
      do_tick();
      for (int ch = 0; ch < NC; ch++) begin
        chk(slow ? (ch == 0 ? "R2" : "R3") : "R7", $sformatf("en ch%0d tick%0d", ch, k),
            int'(sw_en[ch]), int'(k >= e[ch]));
        chk(slow ? ramp_tag(ch) : "R7", $sformatf("ramping ch%0d tick%0d", ch, k),
            int'(sw_ramping[ch]), int'(k >= e[ch] && k < f[ch]));
        chk(slow ? ramp_tag(ch) : "R7", $sformatf("full ch%0d tick%0d", ch, k),
            int'(sw_full[ch]), int'(k >= f[ch]));
      end
      chk("R10", $sformatf("en vs phases tick%0d", k), int'(sw_en), int'(sw_ramping | sw_full));
      chk("R9", $sformatf("done tick%0d", k), int'(seq_done), int'(fin && k == fmax));
      gap();
    end
    chk("R9", "done pulse count", done_seen - d0, fin ? 1 : 0);
    sw_req = '0;
    @(negedge clk);
    chk("R8", "all off after drop", int'(sw_en), 0);
    gap();
  endtask

  initial begin
    int rc[NC];
    int dc[NC-1];
    void'($urandom(32'd4242));
    ramp_code = '0;
    delay_code = '0;
    repeat (3) @(negedge clk);
    chk("R1", "en in reset", int'(sw_en), 0);
    chk("R1", "full in reset", int'(sw_full), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ramping after reset", int'(sw_ramping), 0);
    chk("R1", "done after reset", int'(seq_done), 0);

    // direct mode
    rc = '{3, 4, 5, 6, 2}; dc = '{7, 8, 9, 10};
    run_case(1'b0, 5'b11111, rc, dc);
    // reset-value codes
    rc = '{1, 1, 1, 1, 1}; dc = '{0, 0, 0, 0};
    run_case(1'b1, 5'b11111, rc, dc);
    // microphone code 0 treated as 1, staggered delays
    rc = '{0, 2, 0, 0, 0}; dc = '{1, 3, 2, 0};
    run_case(1'b1, 5'b11111, rc, dc);
    // largest codes
    rc = '{255, 0, 255, 0, 255}; dc = '{255, 0, 0, 0};
    run_case(1'b1, 5'b10111, rc, dc);
    // no left request: others wait
    rc = '{1, 1, 1, 1, 1}; dc = '{0, 0, 0, 0};
    run_case(1'b1, 5'b00110, rc, dc);

    // abort and restart of the microphone switch
    ramp_code = '{8'd1, 8'd1, 8'd10, 8'd1, 8'd1};
    delay_code = '0;
    slow_en = 1'b1;
    sw_req = 5'b11111;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin do_tick(); gap(); end
    sw_req[2] = 1'b0;
    @(negedge clk);
    chk("R8", "mic off after drop", int'(sw_en[2]), 0);
    chk("R8", "left keeps ramping", int'(sw_ramping[0]), 1);
    sw_req[2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "mic waits for tick", int'(sw_en[2]), 0);
    do_tick(); gap();
    chk("R8", "mic restarts ramp", int'(sw_ramping[2]), 1);
    chk("R4", "left full", int'(sw_full[0]), 1);
    for (int k = 0; k < 22; k++) begin do_tick(); gap(); end
    chk("R5", "mic still ramping", int'(sw_ramping[2]), 1);
    do_tick();
    chk("R5", "mic full after restart", int'(sw_full[2]), 1);
    sw_req = '0;
    repeat (3) @(negedge clk);

    // random cases
    for (int n = 0; n < 14; n++) begin
      for (int ch = 0; ch < NC; ch++) rc[ch] = (ch == 4) ? int'($urandom % 8) : int'($urandom % 30);
      for (int j = 0; j < NC - 1; j++) dc[j] = int'($urandom % 20);
      run_case(($urandom % 4) != 0, 5'($urandom % 32) | (($urandom % 5 != 0) ? 5'b00001 : 5'b00000), rc, dc);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule